// File: doc/BRIEF.md
# Symbol-to-Octet Framing Converter

This block connects a link layer that works in 34-bit symbols to a byte-wide serial port. The top two bits of a symbol give its kind and the lower 32 bits carry its content. In the outbound direction the block pops symbols from a source that shows an empty flag and takes a read strobe. It turns each symbol into a short run of octets, sent most significant first. It delimits control and idle symbols with a flag octet and escapes any content octet that looks like a flag or an escape. The octets go into a sink that shows a full flag and takes a write strobe. The inbound direction works the same way in reverse: it pulls octets, removes escapes, counts content octets and rebuilds symbols. The kind of each rebuilt symbol depends on whether a flag closed the group and how many octets came before it.

After an asynchronous reset the transmitter stays silent for a programmable number of clock cycles, even when a symbol is already waiting. Only then does it begin to transmit. The `link_ready` output tells the link layer that the silence period is over and that at least one idle flag has come in from the far end.

The transmit state machine has the states TX_SILENT, TX_FETCH, TX_BYTE, TX_ESC2 and TX_FLAG:
- TX_SILENT moves to TX_FETCH when the silence timer expires.
- TX_FETCH pops a symbol and goes to TX_FLAG for an idle symbol, or to TX_BYTE for any other kind.
- TX_BYTE either writes a plain octet, or writes an escape octet and goes to TX_ESC2.
- TX_ESC2 writes the escaped octet (original XOR 0x20).
- After the last content octet, both TX_BYTE and TX_ESC2 go to TX_FLAG for a control symbol, or back to TX_FETCH for a data symbol.
- TX_FLAG writes 0x7E and returns to TX_FETCH.

The receive state machine has the states RX_COLLECT, RX_UNESC and RX_EMIT:
- RX_COLLECT goes to RX_UNESC on an escape octet.
- RX_COLLECT goes to RX_EMIT on a flag, or on the content octet that completes a data symbol.
- RX_UNESC returns to RX_COLLECT, or goes to RX_EMIT on the completing octet.
- RX_EMIT holds the symbol until the sink accepts it, then returns to RX_COLLECT.

Top module: `sym_octet_framer`

## Requirements
- R1: After reset is released, no octet is written during the first SILENCE_CYCLES (default 4096) clock edges, even while a symbol is waiting. The first octet is written within four edges after that window ends.
- R2: A symbol with kind field (bits 33:32) equal to 2'b00 (idle) is sent as the single octet 0x7E.
- R3: A symbol with kind 2'b01 or 2'b10 (the two control kinds) is sent as its content bits 31:24, 23:16 and 15:8, in that order, followed by a 0x7E flag. Content bits 7:0 have no effect on the output.
- R4: A symbol with kind 2'b11 (data) is sent as its four content octets, bits 31:24 first, with no flag after them.
- R5: On transmit, a content octet of 0x7D becomes 0x7D 0x5D and one of 0x7E becomes 0x7D 0x5E. Every other value, 0x7F included, is sent as is.
- R6: Inbound, four content octets with no flag between them produce a data symbol of kind 2'b11. The first octet received lands in bits 31:24.
- R7: Inbound, a 0x7E flag that follows exactly three content octets produces a symbol of kind 2'b01. Those octets fill bits 31:8 and bits 7:0 are zero.
- R8: Inbound, a 0x7E flag that follows zero, one or two content octets produces an idle symbol (kind 2'b00, content zero). The partial octets are discarded.
- R9: Inbound, 0x7D followed by any octet b yields the content octet b XOR 0x20, and that octet counts toward the content count.
- R10: No octet is written while the octet sink is full, and no symbol is written while the symbol sink is full. No read is issued to an empty source. Under any pattern of backpressure the streams arrive complete, in order and without repeats.
- R11: `link_ready` is low during and after reset until the silence window has ended and an inbound flag has produced an idle symbol. From then on it stays high until the next reset.
- R12: The inbound side never emits a symbol of kind 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_sym_empty | input | 1 | Outbound symbol source has no symbol |
| tx_sym_rd | output | 1 | Pops the outbound symbol at this edge |
| tx_sym | input | 34 | Outbound symbol: kind in 33:32, content in 31:0 |
| tx_oct_full | input | 1 | Outbound octet sink cannot accept |
| tx_oct_wr | output | 1 | Writes tx_oct into the octet sink at this edge |
| tx_oct | output | 8 | Outbound octet |
| rx_oct_empty | input | 1 | Inbound octet source has no octet |
| rx_oct_rd | output | 1 | Pops the inbound octet at this edge |
| rx_oct | input | 8 | Inbound octet |
| rx_sym_full | input | 1 | Inbound symbol sink cannot accept |
| rx_sym_wr | output | 1 | Writes rx_sym into the symbol sink at this edge |
| rx_sym | output | 34 | Rebuilt inbound symbol |
| link_ready | output | 1 | Silence over and an idle flag received |

## Verification
The assertions assume that both sources present valid data whenever their empty flag is low, and remove the head item at exactly the edge where the matching read strobe is high. They also assume that empty, full and data inputs change only between clock edges. The bench meets these assumptions with queue models that update all inputs on the falling edge and then take the strobes. It drives its pseudo-random full patterns the same way, so backpressure never changes inside a cycle.

// File: rtl/sof_pkg.sv
`timescale 1ns/1ps
package sof_pkg;

    localparam int OCT_W = 8;

    typedef enum logic [1:0] {
        SYM_IDLE   = 2'b00,
        SYM_CTRL_A = 2'b01,
        SYM_CTRL_B = 2'b10,
        SYM_DATA   = 2'b11
    } sym_kind_e;

    localparam logic [OCT_W-1:0] FLAG_OCT = 8'h7E;
    localparam logic [OCT_W-1:0] ESC_OCT  = 8'h7D;
    localparam logic [OCT_W-1:0] ESC_MASK = 8'h20;

    typedef enum logic [2:0] {
        TX_SILENT,
        TX_FETCH,
        TX_BYTE,
        TX_ESC2,
        TX_FLAG
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_COLLECT,
        RX_UNESC,
        RX_EMIT
    } rx_state_e;

    function automatic logic is_special(input logic [OCT_W-1:0] b);
        return (b == FLAG_OCT) || (b == ESC_OCT);
    endfunction

endpackage

// File: rtl/sof_silence_timer.sv
`timescale 1ns/1ps
module sof_silence_timer #(
    parameter int CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] count_q;

    assign done = (count_q == CNT_W'(CYCLES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!done) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/sof_tx_engine.sv
`timescale 1ns/1ps
module sof_tx_engine
    import sof_pkg::*;
#(
    parameter int CONTENT_OCTS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         silence_done,
    input  logic                         sym_empty,
    output logic                         sym_rd,
    input  logic [OCT_W*CONTENT_OCTS+1:0] sym_word,
    input  logic                         oct_full,
    output logic                         oct_wr,
    output logic [OCT_W-1:0]             oct_data
);
    localparam int CW    = OCT_W * CONTENT_OCTS;
    localparam int SW    = CW + 2;
    localparam int CNT_W = $clog2(CONTENT_OCTS + 1);

    tx_state_e        state_q, state_d;
    logic [CW-1:0]    shreg_q;
    logic [CNT_W-1:0] left_q;
    logic             ctrl_q;

    logic             load, shift;
    sym_kind_e        in_kind;
    logic [OCT_W-1:0] cur;
    logic             last;
    tx_state_e        after_last;

    assign in_kind    = sym_kind_e'(sym_word[SW-1 -: 2]);
    assign cur        = shreg_q[CW-1 -: OCT_W];
    assign last       = (left_q == CNT_W'(1));
    assign after_last = ctrl_q ? TX_FLAG : TX_FETCH;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_SILENT;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        sym_rd   = 1'b0;
        oct_wr   = 1'b0;
        oct_data = cur;
        load     = 1'b0;
        shift    = 1'b0;
        unique case (state_q)
            TX_SILENT: begin
                if (silence_done) state_d = TX_FETCH;
            end
            TX_FETCH: begin
                if (!sym_empty) begin
                    sym_rd  = 1'b1;
                    load    = 1'b1;
                    state_d = (in_kind == SYM_IDLE) ? TX_FLAG : TX_BYTE;
                end
            end
            TX_BYTE: begin
                oct_data = is_special(cur) ? ESC_OCT : cur;
                if (!oct_full) begin
                    oct_wr = 1'b1;
                    if (is_special(cur)) begin
                        state_d = TX_ESC2;
                    end else begin
                        shift   = 1'b1;
                        state_d = last ? after_last : TX_BYTE;
                    end
                end
            end
            TX_ESC2: begin
                oct_data = cur ^ ESC_MASK;
                if (!oct_full) begin
                    oct_wr  = 1'b1;
                    shift   = 1'b1;
                    state_d = last ? after_last : TX_BYTE;
                end
            end
            TX_FLAG: begin
                oct_data = FLAG_OCT;
                if (!oct_full) begin
                    oct_wr  = 1'b1;
                    state_d = TX_FETCH;
                end
            end
            default: state_d = TX_SILENT;
        endcase
    end

    // Content shift register and octet counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            left_q  <= '0;
            ctrl_q  <= 1'b0;
        end else if (load) begin
            unique case (in_kind)
                SYM_DATA: begin
                    shreg_q <= sym_word[CW-1:0];
                    left_q  <= CNT_W'(CONTENT_OCTS);
                    ctrl_q  <= 1'b0;
                end
                SYM_CTRL_A, SYM_CTRL_B: begin
                    shreg_q <= {sym_word[CW-1:OCT_W], {OCT_W{1'b0}}};
                    left_q  <= CNT_W'(CONTENT_OCTS - 1);
                    ctrl_q  <= 1'b1;
                end
                default: begin
                    shreg_q <= '0;
                    left_q  <= '0;
                    ctrl_q  <= 1'b0;
                end
            endcase
        end else if (shift) begin
            shreg_q <= {shreg_q[CW-OCT_W-1:0], {OCT_W{1'b0}}};
            left_q  <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/sof_rx_engine.sv
`timescale 1ns/1ps
module sof_rx_engine
    import sof_pkg::*;
#(
    parameter int CONTENT_OCTS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          oct_empty,
    output logic                          oct_rd,
    input  logic [OCT_W-1:0]              oct_data,
    input  logic                          sym_full,
    output logic                          sym_wr,
    output logic [OCT_W*CONTENT_OCTS+1:0] sym_word,
    output logic                          idle_seen
);
    localparam int CW    = OCT_W * CONTENT_OCTS;
    localparam int SW    = CW + 2;
    localparam int CNT_W = $clog2(CONTENT_OCTS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CONTENT_OCTS - 1);

    rx_state_e        state_q, state_d;
    logic [CW-1:0]    acc_q;
    logic [CNT_W-1:0] got_q;
    logic [SW-1:0]    sym_q;
    logic             idle_seen_q;

    logic             take, is_flag, is_esc, content, completes;
    logic [OCT_W-1:0] value;

    assign take      = oct_rd;
    assign is_flag   = (state_q == RX_COLLECT) && (oct_data == FLAG_OCT);
    assign is_esc    = (state_q == RX_COLLECT) && (oct_data == ESC_OCT);
    assign value     = (state_q == RX_UNESC) ? (oct_data ^ ESC_MASK) : oct_data;
    assign content   = take && !is_flag && !is_esc;
    assign completes = (got_q == LAST_IDX);

    assign sym_word  = sym_q;
    assign idle_seen = idle_seen_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_COLLECT;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        oct_rd  = 1'b0;
        sym_wr  = 1'b0;
        unique case (state_q)
            RX_COLLECT: begin
                oct_rd = !oct_empty;
                if (!oct_empty) begin
                    if (oct_data == FLAG_OCT)      state_d = RX_EMIT;
                    else if (oct_data == ESC_OCT)  state_d = RX_UNESC;
                    else if (completes)            state_d = RX_EMIT;
                end
            end
            RX_UNESC: begin
                oct_rd = !oct_empty;
                if (!oct_empty) state_d = completes ? RX_EMIT : RX_COLLECT;
            end
            RX_EMIT: begin
                sym_wr = !sym_full;
                if (!sym_full) state_d = RX_COLLECT;
            end
            default: state_d = RX_COLLECT;
        endcase
    end

    // Accumulator, octet count and held symbol
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q       <= '0;
            got_q       <= '0;
            sym_q       <= '0;
            idle_seen_q <= 1'b0;
        end else if (take && is_flag) begin
            got_q <= '0;
            if (completes) begin
                sym_q <= {SYM_CTRL_A, acc_q[CW-OCT_W-1:0], {OCT_W{1'b0}}};
            end else begin
                sym_q       <= {SYM_IDLE, {CW{1'b0}}};
                idle_seen_q <= 1'b1;
            end
        end else if (content) begin
            if (completes) begin
                sym_q <= {SYM_DATA, acc_q[CW-OCT_W-1:0], value};
                got_q <= '0;
            end else begin
                acc_q <= {acc_q[CW-OCT_W-1:0], value};
                got_q <= got_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sym_octet_framer.sv
`timescale 1ns/1ps
module sym_octet_framer
    import sof_pkg::*;
#(
    parameter int SILENCE_CYCLES = 4096,
    parameter int CONTENT_OCTS   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tx_sym_empty,
    output logic                          tx_sym_rd,
    input  logic [OCT_W*CONTENT_OCTS+1:0] tx_sym,
    input  logic                          tx_oct_full,
    output logic                          tx_oct_wr,
    output logic [OCT_W-1:0]              tx_oct,
    input  logic                          rx_oct_empty,
    output logic                          rx_oct_rd,
    input  logic [OCT_W-1:0]              rx_oct,
    input  logic                          rx_sym_full,
    output logic                          rx_sym_wr,
    output logic [OCT_W*CONTENT_OCTS+1:0] rx_sym,
    output logic                          link_ready
);
    logic silence_done;
    logic idle_seen;

    sof_silence_timer #(.CYCLES(SILENCE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (silence_done)
    );

    sof_tx_engine #(.CONTENT_OCTS(CONTENT_OCTS)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .silence_done (silence_done),
        .sym_empty    (tx_sym_empty),
        .sym_rd       (tx_sym_rd),
        .sym_word     (tx_sym),
        .oct_full     (tx_oct_full),
        .oct_wr       (tx_oct_wr),
        .oct_data     (tx_oct)
    );

    sof_rx_engine #(.CONTENT_OCTS(CONTENT_OCTS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .oct_empty (rx_oct_empty),
        .oct_rd    (rx_oct_rd),
        .oct_data  (rx_oct),
        .sym_full  (rx_sym_full),
        .sym_wr    (rx_sym_wr),
        .sym_word  (rx_sym),
        .idle_seen (idle_seen)
    );

    assign link_ready = silence_done && idle_seen;
endmodule

// File: rtl/sof_checker.sv
`timescale 1ns/1ps
module sof_checker
    import sof_pkg::*;
#(
    parameter int SILENCE_CYCLES = 4096,
    parameter int CONTENT_OCTS   = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tx_sym_empty,
    input logic                          tx_sym_rd,
    input logic                          tx_oct_full,
    input logic                          tx_oct_wr,
    input logic                          rx_oct_empty,
    input logic                          rx_oct_rd,
    input logic                          rx_sym_full,
    input logic                          rx_sym_wr,
    input logic [OCT_W*CONTENT_OCTS+1:0] rx_sym,
    input logic                          link_ready
);
    localparam int SW    = OCT_W * CONTENT_OCTS + 2;
    localparam int CNT_W = $clog2(SILENCE_CYCLES + 1);

    logic [CNT_W-1:0] edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 edges_q <= '0;
        else if (edges_q != CNT_W'(SILENCE_CYCLES)) edges_q <= edges_q + 1'b1;
    end

    a_r1_quiet_while_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q < CNT_W'(SILENCE_CYCLES)) |-> !tx_oct_wr);

    a_r10_no_oct_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oct_full |-> !tx_oct_wr);

    a_r10_no_sym_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sym_full |-> !rx_sym_wr);

    a_r10_no_sym_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sym_empty |-> !tx_sym_rd);

    a_r10_no_oct_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_oct_empty |-> !rx_oct_rd);

    a_r7_ctrl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sym_wr && rx_sym[SW-1 -: 2] == SYM_CTRL_A) |-> (rx_sym[OCT_W-1:0] == '0));

    a_r8_idle_no_content: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sym_wr && rx_sym[SW-1 -: 2] == SYM_IDLE) |-> (rx_sym[SW-3:0] == '0));

    a_r12_no_ctrl_b_inbound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sym_wr |-> (rx_sym[SW-1 -: 2] != SYM_CTRL_B));

    a_r11_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready |=> link_ready);

    a_r11_ready_after_silence: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready |-> (edges_q == CNT_W'(SILENCE_CYCLES)));
endmodule

bind sym_octet_framer sof_checker #(
    .SILENCE_CYCLES (SILENCE_CYCLES),
    .CONTENT_OCTS   (CONTENT_OCTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_sym_empty (tx_sym_empty),
    .tx_sym_rd    (tx_sym_rd),
    .tx_oct_full  (tx_oct_full),
    .tx_oct_wr    (tx_oct_wr),
    .rx_oct_empty (rx_oct_empty),
    .rx_oct_rd    (rx_oct_rd),
    .rx_sym_full  (rx_sym_full),
    .rx_sym_wr    (rx_sym_wr),
    .rx_sym       (rx_sym),
    .link_ready   (link_ready)
);

// File: tb/sim_sym_octet_framer.sv
`timescale 1ns/1ps
module sim_sym_octet_framer;
    localparam int SIL = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_sym_empty = 1'b1;
    logic        tx_sym_rd;
    logic [33:0] tx_sym = '0;
    logic        tx_oct_full = 1'b0;
    logic        tx_oct_wr;
    logic [7:0]  tx_oct;
    logic        rx_oct_empty = 1'b1;
    logic        rx_oct_rd;
    logic [7:0]  rx_oct = '0;
    logic        rx_sym_full = 1'b0;
    logic        rx_sym_wr;
    logic [33:0] rx_sym;
    logic        link_ready;

    always #10 clk = ~clk;

    sym_octet_framer u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_sym_empty(tx_sym_empty), .tx_sym_rd(tx_sym_rd), .tx_sym(tx_sym),
        .tx_oct_full(tx_oct_full), .tx_oct_wr(tx_oct_wr), .tx_oct(tx_oct),
        .rx_oct_empty(rx_oct_empty), .rx_oct_rd(rx_oct_rd), .rx_oct(rx_oct),
        .rx_sym_full(rx_sym_full), .rx_sym_wr(rx_sym_wr), .rx_sym(rx_sym),
        .link_ready(link_ready)
    );

    logic [33:0] txq[$];
    logic [7:0]  octq[$];
    logic [7:0]  rxq[$];
    logic [33:0] symq[$];
    bit          oct_stall = 1'b0;
    bit          sym_stall = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          edge_cnt = 0;
    int          first_wr = -1;
    int          n_checks = 0;
    int          n_errs = 0;

    // Edge counter since reset release
    initial forever begin
        @(posedge clk);
        if (rst_n) edge_cnt++;
    end

    // Source and sink models: inputs change on the falling edge
    initial forever begin
        @(negedge clk);
        lfsr         = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_sym_empty = (txq.size() == 0);
        tx_sym       = tx_sym_empty ? '0 : txq[0];
        rx_oct_empty = (rxq.size() == 0);
        rx_oct       = rx_oct_empty ? '0 : rxq[0];
        tx_oct_full  = oct_stall && lfsr[0];
        rx_sym_full  = sym_stall && lfsr[3];
        #1;
        if (rst_n) begin
            if (tx_sym_rd) void'(txq.pop_front());
            if (rx_oct_rd) void'(rxq.pop_front());
            if (tx_oct_wr) begin
                octq.push_back(tx_oct);
                if (first_wr < 0) first_wr = edge_cnt + 1;
            end
            if (rx_sym_wr) symq.push_back(rx_sym);
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_oct(input int n);
        int k = 0;
        while (octq.size() < n && k < 2000) begin @(negedge clk); k++; end
        repeat (30) @(negedge clk);
    endtask

    task automatic wait_sym(input int n);
        int k = 0;
        while (symq.size() < n && k < 2000) begin @(negedge clk); k++; end
        repeat (30) @(negedge clk);
    endtask

    // Push one symbol and compare the octet stream (exp left-aligned, n octets)
    task automatic tx_case(input logic [33:0] s, input logic [63:0] exp, input int n, input string tag);
        txq.push_back(s);
        wait_oct(n);
        check(octq.size() == n, {tag, " octet count"}, octq.size(), n);
        for (int i = 0; i < n; i++) begin
            if (i < octq.size())
                check(octq[i] == exp[63-8*i -: 8], tag, octq[i], exp[63-8*i -: 8]);
        end
        octq.delete();
    endtask

    // Push n octets and expect exactly one symbol
    task automatic rx_case(input logic [63:0] b, input int n, input logic [33:0] exp, input string tag);
        for (int i = 0; i < n; i++) rxq.push_back(b[63-8*i -: 8]);
        wait_sym(1);
        check(symq.size() == 1, {tag, " symbol count"}, symq.size(), 1);
        if (symq.size() > 0) check(symq[0] === exp, tag, symq[0], exp);
        symq.delete();
    endtask

    task automatic t_reset();
        txq.push_back({2'b00, 32'h0});
        repeat (3) @(negedge clk);
        check(tx_oct_wr == 1'b0, "R1 no octet in reset", tx_oct_wr, 0);
        check(rx_sym_wr == 1'b0, "R10 no symbol in reset", rx_sym_wr, 0);
        check(link_ready == 1'b0, "R11 link_ready low in reset", link_ready, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_silence();
        int k = 0;
        while (octq.size() < 1 && k < SIL + 100) begin @(negedge clk); k++; end
        repeat (10) @(negedge clk);
        check(first_wr > SIL, "R1 silent window kept", first_wr, SIL + 1);
        check(first_wr <= SIL + 4, "R1 sending starts after window", first_wr, SIL + 4);
        check(octq.size() == 1 && octq[0] == 8'h7E, "R2 idle flag after silence",
              octq.size() > 0 ? octq[0] : 8'hxx, 8'h7E);
        check(link_ready == 1'b0, "R11 not ready without inbound flag", link_ready, 0);
        octq.delete();
    endtask

    task automatic t_tx_kinds();
        tx_case({2'b00, 32'h0},        64'h7E00000000000000, 1, "R2 idle");
        tx_case({2'b01, 32'h12345699}, 64'h1234567E00000000, 4, "R3 control low byte ignored");
        tx_case({2'b10, 32'h7D7D7D00}, 64'h7D5D7D5D7D5D7E00, 7, "R5 control escapes 7D");
        tx_case({2'b01, 32'h7E7E7E11}, 64'h7D5E7D5E7D5E7E00, 7, "R5 control escapes 7E");
        tx_case({2'b10, 32'h7D7F7E00}, 64'h7D5D7F7D5E7E0000, 6, "R5 control 7F unchanged");
        tx_case({2'b11, 32'h12345678}, 64'h1234567800000000, 4, "R4 data no flag");
        tx_case({2'b11, 32'h7D7D7D7D}, 64'h7D5D7D5D7D5D7D5D, 8, "R5 data escapes 7D");
        tx_case({2'b11, 32'h7E7E7E7E}, 64'h7D5E7D5E7D5E7D5E, 8, "R5 data escapes 7E");
        tx_case({2'b11, 32'h7D7F7E7F}, 64'h7D5D7F7D5E7F0000, 6, "R4 data mixed");
    endtask

    task automatic t_rx_kinds();
        rx_case(64'h7E00000000000000, 1, {2'b00, 32'h0}, "R8 lone flag idle");
        check(link_ready == 1'b1, "R11 ready after idle flag", link_ready, 1);
        rx_case(64'h127E000000000000, 2, {2'b00, 32'h0}, "R8 one octet dropped");
        rx_case(64'h34567E0000000000, 3, {2'b00, 32'h0}, "R8 two octets dropped");
        rx_case(64'h789ABC7E00000000, 4, {2'b01, 32'h789ABC00}, "R7 R12 control rebuilt");
        rx_case(64'h7D5D7D5D7D5D7E00, 7, {2'b01, 32'h7D7D7D00}, "R9 control unescaped");
        rx_case(64'hF111223300000000, 4, {2'b11, 32'hF1112233}, "R6 data rebuilt");
        rx_case(64'h7D5D7D5D7D5D7D5D, 8, {2'b11, 32'h7D7D7D7D}, "R9 data unescaped 7D");
        rx_case(64'h7D5E7D5E7D5E7D5E, 8, {2'b11, 32'h7E7E7E7E}, "R9 data unescaped 7E");
        check(link_ready == 1'b1, "R11 ready stays high", link_ready, 1);
    endtask

    task automatic t_stall();
        logic [7:0]  exp_o[$];
        logic [33:0] exp_s[$];
        oct_stall = 1'b1;
        sym_stall = 1'b1;
        exp_o = '{8'h7D,8'h5D,8'h11,8'h22,8'h33, 8'h7D,8'h5E,8'h55,8'h66,8'h7E,
                  8'h7E, 8'h44,8'h55,8'h66,8'h77};
        exp_s = '{{2'b11,32'h44556677}, {2'b11,32'h8899AABB}, {2'b00,32'h0},
                  {2'b01,32'h7E010200}};
        txq.push_back({2'b11, 32'h7D112233});
        txq.push_back({2'b01, 32'h7E5566AB});
        txq.push_back({2'b00, 32'h0});
        txq.push_back({2'b11, 32'h44556677});
        foreach (exp_o[i]) ;
        rxq = '{8'h44,8'h55,8'h66,8'h77,8'h88,8'h99,8'hAA,8'hBB,8'h7E,
                8'h7D,8'h5E,8'h01,8'h02,8'h7E};
        wait_oct(exp_o.size());
        wait_sym(exp_s.size());
        check(octq.size() == exp_o.size(), "R10 octet count under stall", octq.size(), exp_o.size());
        check(symq.size() == exp_s.size(), "R10 symbol count under stall", symq.size(), exp_s.size());
        for (int i = 0; i < exp_o.size(); i++)
            if (i < octq.size()) check(octq[i] == exp_o[i], "R10 octet order under stall", octq[i], exp_o[i]);
        for (int i = 0; i < exp_s.size(); i++)
            if (i < symq.size()) check(symq[i] === exp_s[i], "R10 symbol order under stall", symq[i], exp_s[i]);
        octq.delete();
        symq.delete();
        oct_stall = 1'b0;
        sym_stall = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_silence();
        t_tx_kinds();
        t_rx_kinds();
        t_stall();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule